// File: doc/BRIEF.md
# Pin Edge and Level Event Detector

This block watches a bank of external pin inputs and raises per-pin event flags according to a small trigger code held for each pin. Each pin is first brought into the clock domain through a short synchronizer chain. The current synchronized sample is then compared with the sample from the previous cycle to find rising and falling edges, and its value is used directly for level triggers. Depending on its code, a pin can send its flag to one shared interrupt line, raise a per-pin transfer request for a DMA engine, record an edge without signalling anything, or drive a trigger strobe that tracks the pin.

Software clears flags by writing ones to a status word; bits written as zero are left alone. The DMA engine clears the flags of pins set for transfer requests by pulsing a per-pin completion input. If a level trigger's level is still present, its flag stays set through any clear, so a held level keeps the interrupt asserted.

Top module: `pin_event_detector`

## Requirements
- R1: While reset is active and just after it ends, every status bit, `irq_o`, every `dma_req_o` bit and every `trig_out_o` bit is low.
- R2: Codes 1, 2 and 3 set the pin's flag on a rising, falling or any edge respectively. While that flag is set, the pin's `dma_req_o` bit is high. These codes never drive `irq_o`.
- R3: Codes 5, 6 and 7 set the flag on a rising, falling or any edge respectively. They raise neither `irq_o` nor `dma_req_o`.
- R4: Codes 9, 10 and 11 set the flag on a rising, falling or any edge respectively, and the flag drives `irq_o`.
- R5: Code 8 sets the flag whenever the synchronized pin is low, and code 12 whenever it is high. If the level is still present when a clear arrives, the flag reads as set in the very next cycle.
- R6: Code 13 makes `trig_out_o[n]` equal the synchronized pin, and code 14 makes it equal the inverted pin. These codes never set a flag. Every other code holds `trig_out_o[n]` low.
- R7: Codes 0, 4 and 15 never set a flag and never drive `irq_o`, `dma_req_o` or `trig_out_o`.
- R8: A cycle with `stat_wr_i` high clears every flag whose `stat_wdata_i` bit is one and leaves the others unchanged. Status bit n belongs to pin n, so the value 0x00010001 means pins 0 and 16 are flagged.
- R9: `dma_done_i[n]` clears flag n only when pin n holds code 1, 2 or 3. For any other code it has no effect.
- R10: `irq_o` is high exactly when at least one flagged pin holds a code from 8 to 12.
- R11: A pin change applied before rising clock edge k is visible in `stat_o` after edge k+2, and is not yet visible after edge k+1 (default of two synchronizer stages).
- R12: The trigger code of pin n is held in bits 4n+3 down to 4n of `trig_cfg_i`. The history of the edge detector resets to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Raw, asynchronous pin levels |
| trig_cfg_i | input | 4*NUM_PINS | Trigger code per pin, 4 bits each |
| stat_wr_i | input | 1 | Status clear strobe |
| stat_wdata_i | input | NUM_PINS | Write-one-to-clear mask |
| dma_done_i | input | NUM_PINS | Per-pin transfer completion pulse |
| stat_o | output | NUM_PINS | Per-pin event flags |
| irq_o | output | 1 | Combined interrupt |
| dma_req_o | output | NUM_PINS | Per-pin transfer request |
| trig_out_o | output | NUM_PINS | Per-pin trigger strobe following the pin |

## Verification
The assertions assume that the trigger code of a pin stays stable for the cycle in which a clear is applied, and that each pin level lasts at least one synchronized sample, so that every level change is seen as exactly one edge. The stimulus changes trigger codes only while the pins are quiet. It holds every new pin pattern for several cycles before the next one, and pulses the clear and completion inputs for one cycle at a time while the pins are stable. Under these conditions the bench model can count exactly one edge for each pin transition.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

   localparam int TRIG_W = 4;

   // trigger code points; the numeric values are part of the interface
   localparam logic [TRIG_W-1:0] TC_OFF       = 4'd0;
   localparam logic [TRIG_W-1:0] TC_DMA_RISE  = 4'd1;
   localparam logic [TRIG_W-1:0] TC_DMA_FALL  = 4'd2;
   localparam logic [TRIG_W-1:0] TC_DMA_ANY   = 4'd3;
   localparam logic [TRIG_W-1:0] TC_FLG_RISE  = 4'd5;
   localparam logic [TRIG_W-1:0] TC_FLG_FALL  = 4'd6;
   localparam logic [TRIG_W-1:0] TC_FLG_ANY   = 4'd7;
   localparam logic [TRIG_W-1:0] TC_IRQ_LOW   = 4'd8;
   localparam logic [TRIG_W-1:0] TC_IRQ_RISE  = 4'd9;
   localparam logic [TRIG_W-1:0] TC_IRQ_FALL  = 4'd10;
   localparam logic [TRIG_W-1:0] TC_IRQ_ANY   = 4'd11;
   localparam logic [TRIG_W-1:0] TC_IRQ_HIGH  = 4'd12;
   localparam logic [TRIG_W-1:0] TC_TRG_HIGH  = 4'd13;
   localparam logic [TRIG_W-1:0] TC_TRG_LOW   = 4'd14;

   typedef struct packed {
      logic on_rise;
      logic on_fall;
      logic on_low;
      logic on_high;
      logic to_dma;
      logic to_irq;
      logic trg_en;
      logic trg_inv;
   } trig_dec_t;

   function automatic trig_dec_t trig_decode(input logic [TRIG_W-1:0] code);
      trig_dec_t d;
      d = '0;
      case (code)
         TC_DMA_RISE: begin d.on_rise = 1'b1; d.to_dma = 1'b1; end
         TC_DMA_FALL: begin d.on_fall = 1'b1; d.to_dma = 1'b1; end
         TC_DMA_ANY:  begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.to_dma = 1'b1; end
         TC_FLG_RISE: d.on_rise = 1'b1;
         TC_FLG_FALL: d.on_fall = 1'b1;
         TC_FLG_ANY:  begin d.on_rise = 1'b1; d.on_fall = 1'b1; end
         TC_IRQ_LOW:  begin d.on_low  = 1'b1; d.to_irq = 1'b1; end
         TC_IRQ_RISE: begin d.on_rise = 1'b1; d.to_irq = 1'b1; end
         TC_IRQ_FALL: begin d.on_fall = 1'b1; d.to_irq = 1'b1; end
         TC_IRQ_ANY:  begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.to_irq = 1'b1; end
         TC_IRQ_HIGH: begin d.on_high = 1'b1; d.to_irq = 1'b1; end
         TC_TRG_HIGH: d.trg_en = 1'b1;
         TC_TRG_LOW:  begin d.trg_en = 1'b1; d.trg_inv = 1'b1; end
         default:     d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 1) begin : g_bad
         $error("pin_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[LAST];

endmodule

// File: rtl/pin_event_cell.sv
module pin_event_cell
   import pin_evt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_i,
   input  logic [TRIG_W-1:0] code_i,
   input  logic              wr_clr_i,
   input  logic              dma_done_i,
   output logic              flag_o,
   output logic              dma_req_o,
   output logic              irq_src_o,
   output logic              trg_o
);

   trig_dec_t dec;
   logic      prev_q;
   logic      flag_q;
   logic      flag_d;
   logic      rise;
   logic      fall;
   logic      hit;
   logic      clr;

   always_comb begin
      dec    = trig_decode(code_i);
      rise   = smp_i & ~prev_q;
      fall   = ~smp_i & prev_q;
      hit    = (dec.on_rise & rise) | (dec.on_fall & fall)
             | (dec.on_low & ~smp_i) | (dec.on_high & smp_i);
      clr    = wr_clr_i | (dma_done_i & dec.to_dma);
      // a new event outranks a clear in the same cycle
      flag_d = hit | (flag_q & ~clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= smp_i;
         flag_q <= flag_d;
      end
   end

   assign flag_o    = flag_q;
   assign dma_req_o = flag_q & dec.to_dma;
   assign irq_src_o = flag_q & dec.to_irq;
   assign trg_o     = dec.trg_en & (smp_i ^ dec.trg_inv);

   // R5
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(dec.on_high & smp_i) || $past(dec.on_low & ~smp_i))) |-> flag_q);

   // R7
   silent_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(dec.on_rise | dec.on_fall | dec.on_low | dec.on_high));

   // R8
   wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr_i && !dec.on_low && !dec.on_high && (smp_i == prev_q)) |=> !flag_q);

endmodule

// File: rtl/pin_irq_merge.sv
module pin_irq_merge #(
   parameter int NUM = 32
) (
   input  logic [NUM-1:0] src_i,
   output logic           irq_o
);

   assign irq_o = |src_i;

endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
   import pin_evt_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int CODE_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        pin_i,
   input  logic [CODE_W*NUM_PINS-1:0] trig_cfg_i,
   input  logic                       stat_wr_i,
   input  logic [NUM_PINS-1:0]        stat_wdata_i,
   input  logic [NUM_PINS-1:0]        dma_done_i,
   output logic [NUM_PINS-1:0]        stat_o,
   output logic                       irq_o,
   output logic [NUM_PINS-1:0]        dma_req_o,
   output logic [NUM_PINS-1:0]        trig_out_o
);

   generate
      if (CODE_W != TRIG_W) begin : g_bad_code
         $error("pin_event_detector: CODE_W must equal the package code width");
      end
      if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
         $error("pin_event_detector: NUM_PINS must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pin_event_detector: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_PINS-1:0] smp;
   logic [NUM_PINS-1:0] irq_src;

   pin_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i),
      .sync_o  (smp)
   );

   generate
      for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
         pin_event_cell i_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp_i      (smp[n]),
            .code_i     (trig_cfg_i[n*CODE_W +: CODE_W]),
            .wr_clr_i   (stat_wr_i & stat_wdata_i[n]),
            .dma_done_i (dma_done_i[n]),
            .flag_o     (stat_o[n]),
            .dma_req_o  (dma_req_o[n]),
            .irq_src_o  (irq_src[n]),
            .trg_o      (trig_out_o[n])
         );
      end
   endgenerate

   pin_irq_merge #(
      .NUM (NUM_PINS)
   ) i_merge (
      .src_i (irq_src),
      .irq_o (irq_o)
   );

   // R10
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (stat_o != '0));

   // R2
   dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dma_req_o & ~stat_o) == '0));

endmodule

// File: tb/test_pin_event_detector.sv
`timescale 1ns/1ps
module test_pin_event_detector;

   localparam int N = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   pin_i = '0;
   logic [4*N-1:0] trig_cfg_i = '0;
   logic           stat_wr_i = 1'b0;
   logic [N-1:0]   stat_wdata_i = '0;
   logic [N-1:0]   dma_done_i = '0;
   logic [N-1:0]   stat_o;
   logic           irq_o;
   logic [N-1:0]   dma_req_o;
   logic [N-1:0]   trig_out_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [3:0]   codes [N];
   logic [N-1:0] cur_pins = '0;
   logic [N-1:0] exp_flags = '0;

   always #2 clk = ~clk;

   pin_event_detector i_pin_event_detector (
      .clk          (clk),
      .rst_n        (rst_n),
      .pin_i        (pin_i),
      .trig_cfg_i   (trig_cfg_i),
      .stat_wr_i    (stat_wr_i),
      .stat_wdata_i (stat_wdata_i),
      .dma_done_i   (dma_done_i),
      .stat_o       (stat_o),
      .irq_o        (irq_o),
      .dma_req_o    (dma_req_o),
      .trig_out_o   (trig_out_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // expected behaviour from the trigger code table
   function automatic logic f_edge(input logic [3:0] c, input logic o, input logic n);
      case (c)
         4'd1, 4'd5, 4'd9:  return !o && n;
         4'd2, 4'd6, 4'd10: return o && !n;
         4'd3, 4'd7, 4'd11: return o != n;
         default:           return 1'b0;
      endcase
   endfunction

   function automatic logic f_lvl(input logic [3:0] c, input logic v);
      if (c == 4'd8)  return !v;
      if (c == 4'd12) return v;
      return 1'b0;
   endfunction

   function automatic logic f_dma(input logic [3:0] c);
      return (c >= 4'd1) && (c <= 4'd3);
   endfunction

   function automatic logic f_irq(input logic [3:0] c);
      return (c >= 4'd8) && (c <= 4'd12);
   endfunction

   function automatic logic f_trg(input logic [3:0] c, input logic v);
      if (c == 4'd13) return v;
      if (c == 4'd14) return !v;
      return 1'b0;
   endfunction

   task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      logic [N-1:0] e_dma;
      logic [N-1:0] e_trg;
      logic         e_irq;
      e_irq = 1'b0;
      for (int n = 0; n < N; n++) begin
         e_dma[n] = exp_flags[n] & f_dma(codes[n]);
         e_trg[n] = f_trg(codes[n], cur_pins[n]);
         if (exp_flags[n] && f_irq(codes[n])) e_irq = 1'b1;
      end
      check_vec({tag, " stat_o"},     stat_o,     exp_flags);
      check_vec({tag, " dma_req_o"},  dma_req_o,  e_dma);
      check_vec({tag, " trig_out_o"}, trig_out_o, e_trg);
      check_vec({tag, " irq_o"},      {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, e_irq});
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
      @(negedge clk);
      for (int n = 0; n < N; n++)
         if (f_lvl(codes[n], cur_pins[n])) exp_flags[n] = 1'b1;
   endtask

   // R12: code n occupies bits 4n+3..4n
   task automatic load_codes();
      @(negedge clk);
      for (int n = 0; n < N; n++) trig_cfg_i[4*n +: 4] = codes[n];
      settle();
   endtask

   task automatic apply_pins(input logic [N-1:0] v);
      @(negedge clk);
      for (int n = 0; n < N; n++)
         if (f_edge(codes[n], cur_pins[n], v[n])) exp_flags[n] = 1'b1;
      pin_i    = v;
      cur_pins = v;
      settle();
   endtask

   task automatic write_clear(input logic [N-1:0] m);
      @(negedge clk);
      stat_wr_i    = 1'b1;
      stat_wdata_i = m;
      @(negedge clk);
      stat_wr_i    = 1'b0;
      stat_wdata_i = '0;
      exp_flags    = exp_flags & ~m;
      settle();
   endtask

   task automatic pulse_done(input logic [N-1:0] m);
      @(negedge clk);
      dma_done_i = m;
      @(negedge clk);
      dma_done_i = '0;
      for (int n = 0; n < N; n++)
         if (m[n] && f_dma(codes[n])) exp_flags[n] = 1'b0;
      settle();
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int n = 0; n < N; n++) codes[n] = 4'd0;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_all("R1 after reset");

      // R5 low level, R6 trigger, R7 silent codes, R12 layout
      codes[0]  = 4'd9;  codes[16] = 4'd1;  codes[3] = 4'd5;  codes[4] = 4'd8;
      codes[5]  = 4'd12; codes[6]  = 4'd13; codes[7] = 4'd14; codes[8] = 4'd4;
      codes[9]  = 4'd15; codes[10] = 4'd0;  codes[11] = 4'd10; codes[12] = 4'd6;
      codes[13] = 4'd2;  codes[14] = 4'd3;  codes[15] = 4'd11;
      load_codes();
      check_all("R5 R6 R12 level low and trigger");

      // R11: latency of pin 0 rising edge with code 9
      @(negedge clk);
      pin_i[0]    = 1'b1;
      cur_pins[0] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      check_vec("R11 not yet after two edges", stat_o & 32'h1, 32'h0);
      @(posedge clk);
      @(negedge clk);
      check_vec("R11 visible after third edge", stat_o & 32'h1, 32'h1);
      exp_flags[0] = 1'b1;
      settle();
      check_all("R4 rising edge interrupt");

      // R2 R3 R4 R6 R7: rising edges on many pins
      apply_pins(cur_pins | 32'h0001_C7E9);
      check_all("R2 R3 R6 R7 rising pattern");
      check_vec("R8 pins 0 and 16 flagged", stat_o & 32'h0001_0001, 32'h0001_0001);
      apply_pins(32'h0000_0000);
      check_all("R2 R3 R4 falling pattern");

      // R8: zero writes do nothing, ones clear
      write_clear(32'h0000_0000);
      check_all("R8 zero mask no effect");
      write_clear(32'h0000_0008);
      check_all("R8 clear pin 3");

      // R5: held low level sets again at once
      @(negedge clk);
      stat_wr_i    = 1'b1;
      stat_wdata_i = 32'h0000_0010;
      @(negedge clk);
      stat_wr_i    = 1'b0;
      stat_wdata_i = '0;
      check_vec("R5 level flag back next cycle", stat_o & 32'h10, 32'h10);
      settle();
      check_all("R5 after clear");

      // R9: completion clears only transfer-request pins
      pulse_done(32'hFFFF_FFFF);
      check_all("R9 completion all bits");
      check_vec("R9 interrupt flag kept", stat_o & 32'h1, 32'h1);

      // R10: clear everything, interrupt drops unless a level holds
      write_clear(32'hFFFF_FFFF);
      check_all("R10 after full clear");

      // random phase
      for (int it = 0; it < 48; it++) begin
         if (it % 8 == 0) begin
            for (int n = 0; n < N; n++) codes[n] = 4'($urandom_range(0, 15));
            load_codes();
            check_all("R10 R12 random codes");
         end
         apply_pins($urandom);
         check_all("R2 R3 R4 R5 R6 random pins");
         write_clear($urandom & $urandom);
         check_all("R8 random clear");
         pulse_done($urandom);
         check_all("R9 random completion");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule